// File: doc/BRIEF.md
# Serial Word-Memory Read Slave

This block is the device side of a three-wire serial memory link: chip select, serial clock and serial data in, plus one serial data output with an output enable. Behind the link sits a 128-entry by 16-bit storage array. A parallel load port fills the array before any serial traffic, and the serial side only reads it.

The host raises chip select and may send any number of clocks with data low; these are ignored. The first serial clock rising edge with data high is the start bit. Two opcode bits follow, then a seven-bit address sent most significant bit first. After the last address bit the output turns on and drives a single zero. It then streams the addressed word from bit 15 down to bit 0 and keeps going through the next words, wrapping from the top address to zero, until chip select falls.

A fast system clock samples all three serial inputs through two-flop synchronizers and detects serial clock edges. The serial clock must run at no more than a quarter of the system clock rate.

Top module: `sw_eeprom_rd`

## Requirements
- R1: Start bit, opcode and address bits are taken from `di` only at rising `sk` edges while `cs` is high.
- R2: Rising `sk` edges seen with `di` low before the start bit are dummy clocks and change nothing. The first rising edge with `di` high is the start bit.
- R3: While `cs` is low, `sk` and `di` are ignored, `dout_oe` is 0 and `dout` is 0. Lowering `cs` aborts any command in progress, and the next command needs a fresh start bit.
- R4: On the rising `sk` edge that takes address bit A0, `dout_oe` goes to 1 and `dout` drives a 0 dummy bit.
- R5: Each following rising `sk` edge presents one bit of the addressed word on `dout`, from bit 15 down to bit 0. Between rising edges `dout` does not change.
- R6: After bit 0, further rising `sk` edges with `cs` high stream the word at the next address, starting at its bit 15, with no dummy bit and no new command.
- R7: Sequential reading wraps from address 127 to address 0.
- R8: The two bits after the start bit are the opcode. Only 1 then 0 selects a read. Any other opcode leaves `dout_oe` at 0 until `cs` goes low.
- R9: `dout_oe` stays 0 from the start bit until the rising edge that takes A0. The address is seven bits, sent A6 first.
- R10: When `ld_en` is high at a system clock edge, `ld_data` is written to word `ld_addr`.
- R11: While `rst_n` is low, `dout_oe` and `dout` are 0 and the command sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for `dout`; 0 means high impedance |
| ld_en | input | 1 | Parallel load strobe |
| ld_addr | input | 7 | Parallel load word address |
| ld_data | input | 16 | Parallel load word |

## Verification
The in-module assertions check on every system clock that a low chip select turns the output off, that the output turns on only with a zero dummy bit, that `dout` and its enable move only on a serial clock rising edge, and that a rejected opcode keeps the output off. Only the bench scenarios can show that the bits streamed out match the stored words. These scenarios are a read of every address with a varying number of leading dummy clocks, a multi-word read across the wrap from 127 to 0, a mid-word abort, rejected opcodes, and clocks sent while chip select is low.

// File: rtl/sw_eeprom_rd.sv
module sw_eeprom_rd #(
  parameter int WORDS = 128,
  parameter int WIDTH = 16,
  parameter logic [1:0] RD_OPC = 2'b10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs,
  input  logic                       sk,
  input  logic                       di,
  output logic                       dout,
  output logic                       dout_oe,
  input  logic                       ld_en,
  input  logic [$clog2(WORDS)-1:0]   ld_addr,
  input  logic [WIDTH-1:0]           ld_data
);
  localparam int AW = $clog2(WORDS);
  localparam int CW = $clog2(WIDTH);
  localparam int KW = ((AW > CW) ? AW : CW) + 1;

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADR, S_STREAM, S_HALT} st_t;

  logic [WIDTH-1:0] mem [WORDS];
  logic [1:0] cs_p, sk_p, di_p;
  logic       sk_q;
  st_t        st;
  logic [KW-1:0]    cnt;
  logic             opc_hi;
  logic [AW-1:0]    adr;
  logic [WIDTH-1:0] sh;

  wire cs_s    = cs_p[1];
  wire sk_s    = sk_p[1];
  wire di_s    = di_p[1];
  wire sk_rise = sk_s & ~sk_q;
  wire [AW-1:0] adr_in  = {adr[AW-2:0], di_s};
  wire [AW-1:0] adr_nxt = adr + 1'b1;

  always_ff @(posedge clk)
    if (ld_en) mem[ld_addr] <= ld_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= '0; sk_p <= '0; di_p <= '0; sk_q <= 1'b0;
      st <= S_IDLE; cnt <= '0; opc_hi <= 1'b0; adr <= '0; sh <= '0;
      dout <= 1'b0; dout_oe <= 1'b0;
    end else begin
      cs_p <= {cs_p[0], cs};
      sk_p <= {sk_p[0], sk};
      di_p <= {di_p[0], di};
      sk_q <= sk_s;
      if (!cs_s) begin
        st <= S_IDLE; dout <= 1'b0; dout_oe <= 1'b0; cnt <= '0;
      end else if (sk_rise) begin
        case (st)
          S_IDLE: if (di_s) begin st <= S_OPC; cnt <= '0; end
          S_OPC: begin
            opc_hi <= di_s;
            if (cnt == KW'(1)) begin
              st  <= ({opc_hi, di_s} == RD_OPC) ? S_ADR : S_HALT;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          S_ADR: begin
            adr <= adr_in;
            if (cnt == KW'(AW - 1)) begin
              st <= S_STREAM; dout_oe <= 1'b1; dout <= 1'b0;
              sh <= mem[adr_in]; cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          S_STREAM: begin
            dout <= sh[WIDTH-1];
            if (cnt == KW'(WIDTH - 1)) begin
              adr <= adr_nxt; sh <= mem[adr_nxt]; cnt <= '0;
            end else begin
              sh <= {sh[WIDTH-2:0], 1'b0}; cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_standby_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !dout_oe && !dout);
  assert_dummy_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> !dout && $past(sk_rise));
  assert_step_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s && !sk_rise |=> $stable(dout) && $stable(dout_oe));
  assert_bad_opc_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_HALT |-> !dout_oe);
endmodule

// File: tb/sw_eeprom_rd_test.sv
module sw_eeprom_rd_test;
  logic clk = 0, rst_n = 0, cs = 0, sk = 0, di = 0, ld_en = 0;
  logic [6:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic dout, dout_oe;
  int vectors = 0, errs = 0, cyc = 0;

  sw_eeprom_rd uut (.clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .dout(dout), .dout_oe(dout_oe), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data));

  always #2.5 clk = ~clk;

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 40503 + 12345) ^ (a << 9));
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    @(negedge clk); di = b; sk = 1;
    repeat (4) @(negedge clk);
    sk = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_on;  @(negedge clk); cs = 1; repeat (4) @(negedge clk); endtask
  task automatic cs_off;
    @(negedge clk); cs = 0; repeat (5) @(negedge clk);
    chk("R3 oe off after cs low", dout_oe, 1'b0);
  endtask

  task automatic cmd(input logic [1:0] opc, input int a, input int ndummy);
    for (int i = 0; i < ndummy; i++) begin
      pulse(1'b0);
      chk("R2 dummy clock keeps output off", dout_oe, 1'b0);
    end
    pulse(1'b1);
    pulse(opc[1]); pulse(opc[0]);
    for (int i = 6; i >= 0; i--) begin
      pulse(a[i]);
      if (i > 0) chk("R9 output off during address", dout_oe, 1'b0);
    end
  endtask

  task automatic rd(input int a, input int ndummy, input int nwords);
    cs_on();
    cmd(2'b10, a, ndummy);
    chk("R4 output enabled after A0", dout_oe, 1'b1);
    chk("R4 dummy bit is zero", dout, 1'b0);
    for (int w = 0; w < nwords; w++)
      for (int b = 15; b >= 0; b--) begin
        pulse(1'b0);
        chk(w == 0 ? "R5 word bit" : ((a + w) % 128 < a ? "R7 wrapped word bit" : "R6 next word bit"),
            dout, pat((a + w) % 128)[b]);
      end
    cs_off();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 oe in reset", dout_oe, 1'b0);
    chk("R11 dout in reset", dout, 1'b0);
    rst_n = 1;
    for (int a = 0; a < 128; a++) begin
      @(negedge clk); ld_en = 1; ld_addr = 7'(a); ld_data = pat(a);
    end
    @(negedge clk); ld_en = 0;

    // R10, R1, R5: read every loaded word once, with 0..3 dummy clocks
    for (int a = 0; a < 128; a++) rd(a, a % 4, 1);

    // R6, R7: sequential read across the top address
    rd(125, 2, 5);

    // R8: rejected opcodes keep the output off
    for (int o = 0; o < 4; o++) begin
      if (o == 2) continue;
      cs_on();
      cmd(2'(o), 5, 1);
      for (int i = 0; i < 20; i++) begin
        pulse(1'b1);
        chk("R8 rejected opcode output off", dout_oe, 1'b0);
      end
      cs_off();
    end

    // R3: abort mid-word, then a fresh read works
    cs_on();
    cmd(2'b10, 40, 0);
    for (int b = 15; b >= 11; b--) begin
      pulse(1'b0);
      chk("R5 bit before abort", dout, pat(40)[b]);
    end
    cs_off();
    rd(41, 0, 1);

    // R3, R1: clocks with cs low carry no start bit into the next command
    for (int i = 0; i < 6; i++) begin
      pulse(1'b1);
      chk("R3 cs low ignores clocks", dout_oe, 1'b0);
    end
    cs_on();
    pulse(1'b0);
    chk("R1 no command from cs-low clocks", dout_oe, 1'b0);
    @(negedge clk); cs = 0; repeat (5) @(negedge clk);
    rd(77, 1, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule